// File: doc/BRIEF.md
# SMI and SCI Event Aggregator

This block gathers power-management and platform events into sticky status bits. Each status bit has a matching enable bit, and a source raises an interrupt only when both are set. The block drives two active-low outputs. The system-management interrupt, `smi_n_o`, stays asserted until software signals the end of its handler, and then stays released for a guaranteed gap. The system control interrupt, `sci_n_o`, is a plain level that stays low while any enabled SCI source is pending.

One global SCI-enable control bit steers the dual-capable sources to either output. Some sources are fixed to SMI, and one is fixed to SCI. A thermal input sets its status bit on a selectable edge. A write to the command register sets a status bit of its own. A routing field picks the interrupt line that SCI is wired to.

Software uses the block through a four-word register port. Writes are synchronous. Reads are combinational.

Register map:
- Word 0: status. Write 1 to clear a bit.
- Word 1: enable.
- Word 2: control. Bit 0 is the SCI steering enable. Bit 1 is end-of-SMI. Bit 2 selects the thermal edge. Bits 6:4 hold the route.
- Word 3: command code.

Status bit layout:

| Status bit | Source | Class |
|---|---|---|
| 0 | command write | SMI-only |
| 1..4 | `evt_i[3:0]` | SMI-only |
| 5 | `evt_i[4]` | SCI-only |
| 6 | thermal input | dual |
| 7..11 | `evt_i[9:5]` | dual |

Top module: `pm_event_aggregator`

## Requirements
- R1: A status bit is set by a one-cycle event pulse and stays set. It clears only when software writes 1 to its position in word 0. Writing 0 leaves it unchanged.
- R2: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R3: Status bits latch whether or not they are enabled. A source whose enable bit in word 1 is 0 never affects `smi_n_o` or `sci_n_o`.
- R4: Status bits 0 to 4 are SMI-only. When one is pending and enabled, `smi_n_o` goes low one cycle after the status bit sets, whatever the value of control bit 0. These bits never drive `sci_n_o`.
- R5: Status bit 5 is SCI-only. It drives `sci_n_o` low even when control bit 0 is 0, and it never asserts `smi_n_o`.
- R6: Status bits 6 to 11 are dual sources. They go to SCI when control bit 0 is 1 and to SMI when it is 0. Changing control bit 0 moves a pending source from one output to the other.
- R7: Once `smi_n_o` is low, it stays low until software writes 1 to control bit 1 (end-of-SMI), even if every SMI status bit has been cleared.
- R8: End-of-SMI is accepted while `smi_n_o` is low. One cycle after the write, `smi_n_o` goes high for exactly 4 cycles, and control bit 1 reads 1 during that gap. Then the bit clears itself. `smi_n_o` goes low again in the next cycle if an enabled SMI source is still pending.
- R9: A write of 1 to control bit 1 while `smi_n_o` is high is ignored, and the bit reads back 0.
- R10: `sci_n_o` goes low one cycle after any enabled SCI-routed source is pending. It stays low until the last such source is cleared, and goes high one cycle after that.
- R11: The thermal input sets status bit 6 on a rising edge when control bit 2 is 1 and on a falling edge when it is 0. The opposite edge has no effect.
- R12: A write to word 3 stores the 8-bit command code, which reads back from word 3, and sets status bit 0 in the same cycle.
- R13: Control bits 6:4 select the SCI route: 0 to 2 select legacy IRQ 9 to 11, and 3 to 6 select APIC inputs 20 to 23. `sci_route_o` shows the field. A write with the value 7 leaves the field unchanged.
- R14: After reset, status, enable, control and command code read 0, `smi_n_o` and `sci_n_o` are high, and `sci_route_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word select |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected word (combinational) |
| evt_i | input | 10 | One-cycle event pulses from external sources |
| therm_i | input | 1 | Thermal level input |
| smi_n_o | output | 1 | System-management interrupt, active low |
| sci_n_o | output | 1 | System control interrupt, active-low level |
| sci_route_o | output | 3 | SCI routing select |

## Verification
Two functions can land on one status bit in the same cycle: an event pulse that sets the bit, and a software write-1-to-clear of that bit. The bench drives both in one clock cycle, both in a directed case and in the random mix. It then reads the status word and expects the bit to be set. A second collision, a source arriving during the end-of-SMI gap, is provoked by leaving a source pending across the handshake. The check is that `smi_n_o` stays high for exactly four cycles and falls on the next one.

// File: rtl/pmx_pkg.sv
// Package pmx_pkg
// Shared register word addresses, control field positions and the SMI
// sequencer state type for the event aggregator.
// Assumes a two-bit word address on the register port.
package pmx_pkg;

    localparam int unsigned REG_AW = 2;

    localparam logic [REG_AW-1:0] A_STATUS = 2'd0;
    localparam logic [REG_AW-1:0] A_ENABLE = 2'd1;
    localparam logic [REG_AW-1:0] A_CTRL   = 2'd2;
    localparam logic [REG_AW-1:0] A_CMD    = 2'd3;

    localparam int unsigned C_SCIEN    = 0;
    localparam int unsigned C_EOS      = 1;
    localparam int unsigned C_POL      = 2;
    localparam int unsigned C_ROUTE_LO = 4;
    localparam int unsigned ROUTE_W    = 3;
    localparam int unsigned ROUTE_MAX  = 6;

    typedef enum logic [1:0] {
        SMI_IDLE   = 2'd0,
        SMI_ACTIVE = 2'd1,
        SMI_GAP    = 2'd2
    } smi_state_e;

endpackage

// File: rtl/pmx_sticky_bank.sv
// Module pmx_sticky_bank
// A bank of sticky status bits. A set pulse latches a bit. A clear mask
// drops it. A set in the same cycle as a clear wins.
// Assumes set and clear are synchronous to clk.
module pmx_sticky_bank #(
    parameter int unsigned NB = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] sts_o
);

    logic [NB-1:0] sts_q;

    for (genvar i = 0; i < NB; i++) begin : g_bit
        // Hold, clear or set one status bit, set taking priority.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[i] <= 1'b0;
            end else begin
                sts_q[i] <= set_i[i] | (sts_q[i] & ~clr_i[i]);
            end
        end

        // R1: a set bit that is not cleared stays set.
        p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_q[i] && !clr_i[i]) |=> sts_q[i]);

        // R2: a set pulse always leaves the bit set, even with a clear.
        p_set_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> sts_q[i]);
    end

    assign sts_o = sts_q;

endmodule

// File: rtl/pmx_edge_sel.sv
// Module pmx_edge_sel
// Turns a level input into a one-cycle pulse on the edge picked by
// rise_sel_i (1 = rising, 0 = falling).
// Assumes sig_i is already synchronous to clk. The history register loads
// the live level during reset so that no edge is seen at reset release.
module pmx_edge_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic rise_sel_i,
    output logic pulse_o
);

    logic prev_q;

    // Track the previous level of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= sig_i;
        end else begin
            prev_q <= sig_i;
        end
    end

    // Pick the rising or falling transition.
    always_comb begin
        if (rise_sel_i) begin
            pulse_o = sig_i & ~prev_q;
        end else begin
            pulse_o = ~sig_i & prev_q;
        end
    end

    // R11: with a fixed polarity, an edge pulse never lasts two cycles.
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o && $stable(rise_sel_i)) |=> !pulse_o);

endmodule

// File: rtl/pmx_smi_seq.sv
// Module pmx_smi_seq
// SMI sequencer. It asserts smi_n_o when an enabled SMI source is pending
// and holds it until end-of-SMI is accepted. It then releases the line for
// exactly GAP_CYC cycles before it may assert again. The end-of-SMI flag
// is accepted only while the line is asserted, and clears itself after the
// gap.
// Assumes GAP_CYC >= 2.
module pmx_smi_seq
    import pmx_pkg::*;
#(
    parameter int unsigned GAP_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eos_req_i,
    output logic eos_o,
    output logic smi_n_o
);

    localparam int unsigned CW = $clog2(GAP_CYC + 1);

    smi_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          eos_q;

    // Advance the assert / hold / gap sequence and the end-of-SMI flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SMI_IDLE;
            cnt_q   <= '0;
            eos_q   <= 1'b0;
        end else begin
            case (state_q)
                SMI_IDLE: begin
                    if (pend_i) begin
                        state_q <= SMI_ACTIVE;
                    end
                end
                SMI_ACTIVE: begin
                    if (eos_q) begin
                        state_q <= SMI_GAP;
                        cnt_q   <= '0;
                    end else if (eos_req_i) begin
                        eos_q <= 1'b1;
                    end
                end
                SMI_GAP: begin
                    if (cnt_q == CW'(GAP_CYC - 1)) begin
                        state_q <= pend_i ? SMI_ACTIVE : SMI_IDLE;
                        eos_q   <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= SMI_IDLE;
                end
            endcase
        end
    end

    assign smi_n_o = (state_q != SMI_ACTIVE);
    assign eos_o   = eos_q;

    // Checker state: run length of the released line, saturating.
    logic [CW-1:0] hi_run_q;
    logic          seen_low_q;

    // Count cycles with the line high, and note that it has been asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q   <= '0;
            seen_low_q <= 1'b0;
        end else begin
            if (!smi_n_o) begin
                hi_run_q   <= '0;
                seen_low_q <= 1'b1;
            end else if (hi_run_q != CW'(GAP_CYC)) begin
                hi_run_q <= hi_run_q + 1'b1;
            end
        end
    end

    // R7: an asserted line without end-of-SMI stays asserted.
    p_hold_until_eos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_n_o && !eos_q) |=> !smi_n_o);

    // R8: a re-assertion follows at least GAP_CYC released cycles.
    p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(smi_n_o) && seen_low_q) |-> (hi_run_q >= CW'(GAP_CYC)));

    // R9: the end-of-SMI flag never sits set while idle.
    p_eos_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SMI_IDLE) |-> !eos_q);

endmodule

// File: rtl/pm_event_aggregator.sv
// Module pm_event_aggregator
// Top of the SMI / SCI event aggregator. It holds the status, enable,
// control and command-code registers. It maps external pulses, the thermal
// edge and command writes onto status bits. It steers enabled pending
// sources to the SMI sequencer or to the registered SCI level.
// Assumes DW >= number of status bits, DW >= CMD_W and DW >= 7.
module pm_event_aggregator
    import pmx_pkg::*;
#(
    parameter int unsigned SMI_EXT  = 4,
    parameter int unsigned SCI_EXT  = 1,
    parameter int unsigned DUAL_EXT = 5,
    parameter int unsigned GAP_CYC  = 4,
    parameter int unsigned CMD_W    = 8,
    parameter int unsigned DW       = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr_i,
    input  logic [1:0]                            reg_addr_i,
    input  logic [DW-1:0]                         reg_wdata_i,
    output logic [DW-1:0]                         reg_rdata_o,
    input  logic [SMI_EXT+SCI_EXT+DUAL_EXT-1:0]   evt_i,
    input  logic                                  therm_i,
    output logic                                  smi_n_o,
    output logic                                  sci_n_o,
    output logic [2:0]                            sci_route_o
);

    localparam int unsigned N_SRC   = 2 + SMI_EXT + SCI_EXT + DUAL_EXT;
    localparam int unsigned B_CMD   = 0;
    localparam int unsigned SMI_LO  = 1;
    localparam int unsigned SCI_LO  = SMI_LO + SMI_EXT;
    localparam int unsigned B_THERM = SCI_LO + SCI_EXT;
    localparam int unsigned DUAL_LO = B_THERM + 1;

    localparam logic [N_SRC-1:0] M_SMI_ONLY = N_SRC'((1 << (1 + SMI_EXT)) - 1);
    localparam logic [N_SRC-1:0] M_SCI_ONLY = N_SRC'(((1 << SCI_EXT) - 1) << SCI_LO);
    localparam logic [N_SRC-1:0] M_DUAL     = N_SRC'(((1 << (DUAL_EXT + 1)) - 1) << B_THERM);

    logic [N_SRC-1:0]   en_q;
    logic               sci_en_q;
    logic               pol_q;
    logic [ROUTE_W-1:0] route_q;
    logic [CMD_W-1:0]   cmd_q;
    logic               sci_n_q;

    logic               wr_sts, wr_en, wr_ctl, wr_cmd;
    logic [N_SRC-1:0]   set_w, clr_w, sts_w, armed_w;
    logic               therm_pulse;
    logic               smi_pend, sci_pend, eos_w;
    logic [ROUTE_W-1:0] route_wr;

    // Decode the write strobe per register word.
    always_comb begin
        wr_sts = reg_wr_i && (reg_addr_i == A_STATUS);
        wr_en  = reg_wr_i && (reg_addr_i == A_ENABLE);
        wr_ctl = reg_wr_i && (reg_addr_i == A_CTRL);
        wr_cmd = reg_wr_i && (reg_addr_i == A_CMD);
    end

    assign route_wr = reg_wdata_i[C_ROUTE_LO +: ROUTE_W];

    // Select the active thermal edge.
    pmx_edge_sel u_therm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (therm_i),
        .rise_sel_i (pol_q),
        .pulse_o    (therm_pulse)
    );

    // Place every source onto its status bit position.
    always_comb begin
        set_w                     = '0;
        set_w[B_CMD]              = wr_cmd;
        set_w[SMI_LO +: SMI_EXT]  = evt_i[SMI_EXT-1:0];
        set_w[SCI_LO +: SCI_EXT]  = evt_i[SMI_EXT +: SCI_EXT];
        set_w[B_THERM]            = therm_pulse;
        set_w[DUAL_LO +: DUAL_EXT] = evt_i[SMI_EXT + SCI_EXT +: DUAL_EXT];
        clr_w                     = wr_sts ? reg_wdata_i[N_SRC-1:0] : '0;
    end

    // Sticky status bits.
    pmx_sticky_bank #(
        .NB (N_SRC)
    ) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_w),
        .clr_i (clr_w),
        .sts_o (sts_w)
    );

    // Enable, control and command-code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            sci_en_q <= 1'b0;
            pol_q    <= 1'b0;
            route_q  <= '0;
            cmd_q    <= '0;
        end else begin
            if (wr_en) begin
                en_q <= reg_wdata_i[N_SRC-1:0];
            end
            if (wr_ctl) begin
                sci_en_q <= reg_wdata_i[C_SCIEN];
                pol_q    <= reg_wdata_i[C_POL];
                if (route_wr <= ROUTE_W'(ROUTE_MAX)) begin
                    route_q <= route_wr;
                end
            end
            if (wr_cmd) begin
                cmd_q <= reg_wdata_i[CMD_W-1:0];
            end
        end
    end

    // Steer pending enabled sources to SMI or SCI by class and by the global enable.
    always_comb begin
        armed_w  = sts_w & en_q;
        smi_pend = |(armed_w & (M_SMI_ONLY | (sci_en_q ? '0 : M_DUAL)));
        sci_pend = |(armed_w & (M_SCI_ONLY | (sci_en_q ? M_DUAL : '0)));
    end

    // SMI assert / end-of-SMI / gap sequence.
    pmx_smi_seq #(
        .GAP_CYC (GAP_CYC)
    ) u_smi (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_i    (smi_pend),
        .eos_req_i (wr_ctl && reg_wdata_i[C_EOS]),
        .eos_o     (eos_w),
        .smi_n_o   (smi_n_o)
    );

    // Register the SCI level, active low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sci_n_q <= 1'b1;
        end else begin
            sci_n_q <= ~sci_pend;
        end
    end

    assign sci_n_o     = sci_n_q;
    assign sci_route_o = route_q;

    // Return the selected register word.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_STATUS: reg_rdata_o[N_SRC-1:0] = sts_w;
            A_ENABLE: reg_rdata_o[N_SRC-1:0] = en_q;
            A_CTRL: begin
                reg_rdata_o[C_SCIEN]                = sci_en_q;
                reg_rdata_o[C_EOS]                  = eos_w;
                reg_rdata_o[C_POL]                  = pol_q;
                reg_rdata_o[C_ROUTE_LO +: ROUTE_W]  = route_q;
            end
            default:  reg_rdata_o[CMD_W-1:0] = cmd_q;
        endcase
    end

    // R12: a command-code write sets its status bit in the next cycle.
    p_cmd_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> sts_w[B_CMD]);

    // R13: the route field only ever holds a legal selection.
    p_route_legal_r13: assert property (@(posedge clk) disable iff (!rst_n)
        route_q <= ROUTE_W'(ROUTE_MAX));

    // R3: with nothing enabled, neither output is asserted a cycle later.
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(armed_w == '0) && armed_w == '0 && $past(smi_n_o)) |-> (sci_n_o && smi_n_o));

endmodule

// File: tb/pm_event_aggregator_test.sv
module pm_event_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [9:0]  evt = 10'd0;
    logic        therm = 1'b0;
    logic        smi_n, sci_n;
    logic [2:0]  route;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pm_event_aggregator uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .therm_i     (therm),
        .smi_n_o     (smi_n),
        .sci_n_o     (sci_n),
        .sci_route_o (route)
    );

    localparam logic [1:0] W_STS = 2'd0, W_EN = 2'd1, W_CTL = 2'd2, W_CMD = 2'd3;

    function automatic logic [15:0] ctl(input logic s, input logic e, input logic p, input logic [2:0] r);
        return {9'd0, r, 1'b0, p, e, s};
    endfunction

    function automatic logic [11:0] evt_map(input logic [9:0] v);
        return {v[9:5], 1'b0, v[4], v[3:0], 1'b0};
    endfunction

    function automatic logic exp_sci_n(input logic [11:0] s, input logic [11:0] e, input logic sen);
        return ~|(s & e & (12'h020 | (sen ? 12'hFC0 : 12'h000)));
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [9:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
        evt = 10'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [11:0] e_sts, e_en;
        logic        e_sen;
        int unsigned seed;
        seed = $urandom(32'h5EED0042);

        do_reset();
        // R14: reset state
        rd(W_STS, d); chk("R14 status", d, 0);
        rd(W_EN, d);  chk("R14 enable", d, 0);
        rd(W_CTL, d); chk("R14 control", d, 0);
        rd(W_CMD, d); chk("R14 command", d, 0);
        chk("R14 smi_n", smi_n, 1);
        chk("R14 sci_n", sci_n, 1);
        chk("R14 route", route, 0);

        // R9: end-of-SMI while released is dropped
        wr(W_CTL, ctl(0, 1, 1, 0));
        rd(W_CTL, d); chk("R9 eos ignored", d, 16'h0004);

        // R1 / R3: latch without enable, no interrupt
        pulse(10'h001); idle(1);
        rd(W_STS, d); chk("R1 latch", d, 16'h0002);
        chk("R3 masked smi", smi_n, 1);
        chk("R3 masked sci", sci_n, 1);
        wr(W_STS, 16'h0000);
        rd(W_STS, d); chk("R1 write zero keeps", d, 16'h0002);
        wr(W_STS, 16'h0002);
        rd(W_STS, d); chk("R1 w1c", d, 0);

        // R2: set and clear collide on bit 2
        @(negedge clk);
        evt = 10'h002; reg_wr = 1'b1; reg_addr = W_STS; reg_wdata = 16'h0004;
        @(negedge clk);
        evt = 10'd0; reg_wr = 1'b0;
        rd(W_STS, d); chk("R2 set wins", d, 16'h0004);
        wr(W_STS, 16'h0004);

        // R12: command write
        wr(W_CMD, 16'h005A);
        rd(W_CMD, d); chk("R12 code", d, 16'h005A);
        rd(W_STS, d); chk("R12 status", d, 16'h0001);

        // R4: SMI-only source with SCI steering on
        wr(W_CTL, ctl(1, 0, 1, 0));
        wr(W_EN, 16'h0001);
        idle(1);
        chk("R4 smi low", smi_n, 0);
        chk("R4 no sci", sci_n, 1);

        // R7: clear the source, line holds
        wr(W_STS, 16'h0001); idle(3);
        chk("R7 hold", smi_n, 0);

        // R8: end-of-SMI, nothing pending
        wr(W_CTL, ctl(1, 1, 1, 0));
        chk("R8 still low at write", smi_n, 0);
        rd(W_CTL, d); chk("R8 eos reads 1", d, 16'h0007);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); chk("R8 gap high", smi_n, 1);
        end
        @(negedge clk); chk("R8 stays high", smi_n, 1);
        rd(W_CTL, d); chk("R8 eos self clear", d, 16'h0005);

        // R8: end-of-SMI with a source still pending
        wr(W_CMD, 16'h0011); idle(1);
        chk("R8 reassert", smi_n, 0);
        wr(W_CTL, ctl(1, 1, 1, 0));
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); chk("R8 gap with pending", smi_n, 1);
        end
        @(negedge clk); chk("R8 back low after gap", smi_n, 0);
        wr(W_STS, 16'h0001);
        wr(W_CTL, ctl(1, 1, 1, 0)); idle(6);
        chk("R8 released", smi_n, 1);
        wr(W_EN, 16'h0000);

        // R5: SCI-only with steering off
        wr(W_CTL, ctl(0, 0, 1, 0));
        wr(W_EN, 16'h0020);
        pulse(10'h010); idle(1);
        chk("R5 sci low", sci_n, 0);
        chk("R5 no smi", smi_n, 1);

        // R10: two SCI sources, clear one at a time
        wr(W_CTL, ctl(1, 0, 1, 0));
        wr(W_EN, 16'h00A0);
        pulse(10'h020); idle(1);
        rd(W_STS, d); chk("R10 both pending", d, 16'h00A0);
        wr(W_STS, 16'h0020); idle(1);
        chk("R10 one left", sci_n, 0);
        wr(W_STS, 16'h0080);
        chk("R10 one cycle lag", sci_n, 0);
        @(negedge clk); chk("R10 released", sci_n, 1);

        // R6: dual source moves between outputs
        wr(W_EN, 16'h0100);
        pulse(10'h040); idle(1);
        chk("R6 to sci", sci_n, 0);
        chk("R6 not smi", smi_n, 1);
        wr(W_CTL, ctl(0, 0, 1, 0)); idle(1);
        chk("R6 sci released", sci_n, 1);
        chk("R6 to smi", smi_n, 0);
        wr(W_STS, 16'h0100);
        wr(W_CTL, ctl(0, 1, 1, 0)); idle(6);
        chk("R6 smi done", smi_n, 1);
        wr(W_EN, 16'h0000);

        // R11: thermal edge polarity
        @(negedge clk); therm = 1'b1;
        @(negedge clk); rd(W_STS, d); chk("R11 rising", d, 16'h0040);
        wr(W_STS, 16'h0040);
        @(negedge clk); therm = 1'b0;
        @(negedge clk); rd(W_STS, d); chk("R11 falling ignored", d, 0);
        wr(W_CTL, ctl(0, 0, 0, 0));
        @(negedge clk); therm = 1'b1;
        @(negedge clk); rd(W_STS, d); chk("R11 rising ignored", d, 0);
        @(negedge clk); therm = 1'b0;
        @(negedge clk); rd(W_STS, d); chk("R11 falling", d, 16'h0040);
        wr(W_STS, 16'h0040);

        // R13: route field
        wr(W_CTL, ctl(0, 0, 0, 3'd3));
        chk("R13 route 3", route, 3);
        rd(W_CTL, d); chk("R13 readback", d, 16'h0030);
        wr(W_CTL, ctl(0, 0, 0, 3'd7));
        chk("R13 illegal kept", route, 3);
        wr(W_CTL, ctl(0, 0, 0, 3'd6));
        chk("R13 route 6", route, 6);

        // Random mix: status model and SCI level (R1, R2, R10, R6)
        do_reset();
        e_sts = 0; e_en = 0; e_sen = 0;
        for (int i = 0; i < 400; i++) begin
            int unsigned op;
            logic [9:0]  v;
            logic [11:0] m;
            op = $urandom % 6;
            v  = 10'($urandom);
            m  = 12'($urandom);
            case (op)
                0: begin pulse(v); e_sts |= evt_map(v); end
                1: begin wr(W_STS, {4'd0, m}); e_sts &= ~m; end
                2: begin wr(W_EN, {4'd0, m}); e_en = m; end
                3: begin wr(W_CTL, ctl(m[0], 1'b0, 1'b1, 3'd0)); e_sen = m[0]; end
                4: begin wr(W_CMD, {8'd0, m[7:0]}); e_sts |= 12'h001; end
                default: begin
                    @(negedge clk);
                    evt = v; reg_wr = 1'b1; reg_addr = W_STS; reg_wdata = {4'd0, m};
                    @(negedge clk);
                    evt = 10'd0; reg_wr = 1'b0;
                    e_sts = (e_sts & ~m) | evt_map(v);
                end
            endcase
            idle(1);
            rd(W_STS, d); chk("R1 R2 random status", d, {4'd0, e_sts});
            chk("R10 R6 random sci", sci_n, exp_sci_n(e_sts, e_en, e_sen));
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule